// File: doc/BRIEF.md
# Nine-Way Serial Line Code Encoder

This block turns a serial bit stream into one of nine line codes. Each output symbol is a 2-bit signed level: 00 is zero, 01 is positive and 11 is negative. The block is clocked at twice the bit rate. Every bit period is two clocks long, and `half_ph` shows which half of the period the level on `z` belongs to. The upstream logic offers one bit per period, with a valid flag, during the clock in which `half_ph` is high. The block takes that bit at the closing clock edge and starts its symbol on the following clock.

A 4-bit mode word picks the code. The mode word is sampled at the same edge that takes the bit. Two of the codes replace long zero runs with substitution patterns: the eight-zero bipolar code and the four-zero high-density bipolar code. To do this they hold the most recent bits in a short delay line, so the substitution can be written back over zeros that have not yet been sent. All the bipolar codes share one mark-polarity state. The high-density code also keeps a parity of the marks seen since its last substitution.

Top module: `line_encoder`

## Requirements
- R1: While reset is held, `z` is 00 and `half_ph` is low. After release, `half_ph` alternates every clock and starts with a high clock. A bit is accepted at the edge that ends each high clock of `half_ph`.
- R2: Mode 0000, unipolar RZ: a 1 gives 01 in the first half and 00 in the second half. A 0 gives 00 in both halves.
- R3: Mode 0001, NRZ-I: each 1 toggles a level between 00 and 01, and a 0 keeps it. The new level is held for the whole bit. The level is 00 after reset.
- R4: Mode 0010, NRZ-L: a 1 gives 11 and a 0 gives 01, each for the whole bit.
- R5: Mode 0011, Manchester: a 1 gives 01 then 11. A 0 gives 11 then 01.
- R6: Mode 0100, differential Manchester: the level always reverses at mid-bit. A 0 also reverses the level at the start of the bit, and a 1 keeps the level at the start. After reset the previous level counts as negative.
- R7: Mode 0101, AMI: a 0 gives 00 for the whole bit. Each 1 gives a full-bit mark whose sign alternates from mark to mark. The first mark after reset is 01.
- R8: Mode 0110, pseudoternary: the same as R7 with the roles of 1 and 0 swapped.
- R9: Mode 0111, eight-zero substitution: the level for a bit appears 8 accepted bits after that bit. Every run of eight zeros is sent as 0,0,0,V,B,0,V,B, where V repeats the sign of the previous mark and B alternates from it. After a positive mark this gives 00 00 00 01 11 00 11 01. The level is held for the whole bit.
- R10: Mode 1000, four-zero substitution: the level for a bit appears 4 accepted bits after that bit. Every run of four zeros is sent as 0,0,0,V when an odd number of marks has entered since the last substitution, and as B,0,0,V when that number is even. The count starts even.
- R11: Mode codes 1001 to 1111 give 00 in both halves.
- R12: A bit period with the valid flag low gives 00 in both halves. It leaves every code state and the delay line unchanged.
- R13: When the sampled mode differs from the previous one, all polarity, level, parity, run and delay-line state is cleared before the current bit is encoded.
- R14: The first-half level of an accepted bit appears on `z` in the clock after the accept edge, with `half_ph` low. The second-half level follows in the next clock, with `half_ph` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | Line code select, sampled at the accept edge |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Qualifies `bit_in` for the current bit period |
| half_ph | output | 1 | Low during the first half of a symbol, high during the second |
| z | output | 2 | Signed output level: 00 zero, 01 positive, 11 negative |

## Verification
The two levels for a bit accepted at an edge are due in the next two clocks: the first half with `half_ph` low, the second with it high. In the substitution modes they are due 8 or 4 accepted bits later. The bench drives each bit in a high clock of `half_ph` and samples on the falling edges of the next two clocks. It checks both halves and the phase flag against a queue-based model of the codes. That model pushes each bit into a delay list and pops the level that is due. This makes the fixed lag in the substitution modes part of the expected value, rather than a separate wait.

// File: rtl/line_encoder.sv
module line_encoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       bit_in,
  input  logic       bit_valid,
  output logic       half_ph,
  output logic [1:0] z
);

  localparam logic [1:0] LZ = 2'b00;
  localparam logic [1:0] LP = 2'b01;
  localparam logic [1:0] LN = 2'b11;
  localparam logic [1:0] TZ = 2'd0;
  localparam logic [1:0] TM = 2'd1;
  localparam logic [1:0] TV = 2'd2;

  localparam logic [3:0] M_RZ   = 4'd0;
  localparam logic [3:0] M_NRZI = 4'd1;
  localparam logic [3:0] M_NRZL = 4'd2;
  localparam logic [3:0] M_MAN  = 4'd3;
  localparam logic [3:0] M_DMAN = 4'd4;
  localparam logic [3:0] M_AMI  = 4'd5;
  localparam logic [3:0] M_PST  = 4'd6;
  localparam logic [3:0] M_SUB8 = 4'd7;
  localparam logic [3:0] M_SUB4 = 4'd8;

  logic        ph;
  logic [3:0]  mode_q;
  logic [1:0]  z_q, z2_q;
  logic        pol, nrzi, dpol, hpar;
  logic [3:0]  zrun;
  logic [15:0] tline;

  logic        load, chg;
  logic        pol_e, nrzi_e, dpol_e, hpar_e;
  logic [3:0]  zrun_e;
  logic [15:0] tline_e;

  logic [1:0]  f, s;
  logic        pol_n, nrzi_n, dpol_n, hpar_n;
  logic [3:0]  zrun_n;
  logic [15:0] tline_n;
  logic        fpos, mk;
  logic [1:0]  et;

  function automatic logic [1:0] lv(input logic p);
    return p ? LP : LN;
  endfunction

  assign load    = ph;
  assign chg     = load && (mode != mode_q);
  assign pol_e   = chg ? 1'b0  : pol;
  assign nrzi_e  = chg ? 1'b0  : nrzi;
  assign dpol_e  = chg ? 1'b0  : dpol;
  assign hpar_e  = chg ? 1'b0  : hpar;
  assign zrun_e  = chg ? 4'd0  : zrun;
  assign tline_e = chg ? 16'd0 : tline;

  always_comb begin
    f = LZ; s = LZ;
    pol_n = pol_e; nrzi_n = nrzi_e; dpol_n = dpol_e; hpar_n = hpar_e;
    zrun_n = zrun_e; tline_n = tline_e;
    fpos = 1'b0; mk = 1'b0; et = TZ;
    if (bit_valid) begin
      case (mode)
        M_RZ: f = bit_in ? LP : LZ;
        M_NRZI: begin
          nrzi_n = nrzi_e ^ bit_in;
          f = nrzi_n ? LP : LZ;
          s = f;
        end
        M_NRZL: begin
          f = bit_in ? LN : LP;
          s = f;
        end
        M_MAN: begin
          f = bit_in ? LP : LN;
          s = bit_in ? LN : LP;
        end
        M_DMAN: begin
          fpos   = bit_in ? dpol_e : ~dpol_e;
          f      = lv(fpos);
          s      = lv(~fpos);
          dpol_n = ~fpos;
        end
        M_AMI, M_PST: begin
          mk = (mode == M_AMI) ? bit_in : ~bit_in;
          if (mk) begin
            pol_n = ~pol_e;
            f = lv(~pol_e);
          end
          s = f;
        end
        M_SUB8, M_SUB4: begin
          et = (mode == M_SUB8) ? tline_e[15:14] : tline_e[7:6];
          if (et == TM) begin
            pol_n = ~pol_e;
            f = lv(~pol_e);
          end else if (et == TV) begin
            f = lv(pol_e);
          end
          s = f;
          tline_n = {tline_e[13:0], bit_in ? TM : TZ};
          if (bit_in) begin
            zrun_n = 4'd0;
            hpar_n = ~hpar_e;
          end else begin
            zrun_n = zrun_e + 4'd1;
            if (mode == M_SUB8 && zrun_e == 4'd7) begin
              tline_n = {TZ, TZ, TZ, TV, TM, TZ, TV, TM};
              zrun_n  = 4'd0;
            end
            if (mode == M_SUB4 && zrun_e == 4'd3) begin
              tline_n[7:0] = hpar_e ? {TZ, TZ, TZ, TV} : {TM, TZ, TZ, TV};
              zrun_n  = 4'd0;
              hpar_n  = 1'b0;
            end
          end
        end
        default: begin
          f = LZ;
          s = LZ;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0; mode_q <= 4'd0; z_q <= LZ; z2_q <= LZ;
      pol <= 1'b0; nrzi <= 1'b0; dpol <= 1'b0; hpar <= 1'b0;
      zrun <= 4'd0; tline <= 16'd0;
    end else begin
      ph <= ~ph;
      if (load) begin
        mode_q <= mode;
        z_q    <= f;
        z2_q   <= s;
        pol    <= pol_n;
        nrzi   <= nrzi_n;
        dpol   <= dpol_n;
        hpar   <= hpar_n;
        zrun   <= zrun_n;
        tline  <= tline_n;
      end else begin
        z_q <= z2_q;
      end
    end
  end

  assign half_ph = ph;
  assign z       = z_q;

  p_ph_rise_r1: assert property (@(posedge clk) disable iff (!rst_n) !ph |=> ph);
  p_ph_fall_r1: assert property (@(posedge clk) disable iff (!rst_n) ph |=> !ph);
  p_rz_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load && mode == M_RZ |=> ##1 (z == LZ));
  p_nrzl_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load && bit_valid && mode == M_NRZL |=> (z != LZ) ##1 $stable(z));
  p_man_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load && bit_valid && mode == M_MAN |=> z[0] ##1 (z[0] && (z[1] != $past(z[1]))));
  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load && mode > M_SUB4 |=> (z == LZ) ##1 (z == LZ));
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load && !bit_valid |=> (z == LZ) ##1 (z == LZ));

endmodule

// File: tb/line_encoder_bench.sv
`timescale 1ns/1ps
module line_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'd0;
  logic       bit_in = 1'b0;
  logic       bit_valid = 1'b0;
  logic       half_ph;
  logic [1:0] z;

  line_encoder u_line_encoder (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bit_in(bit_in),
    .bit_valid(bit_valid), .half_ph(half_ph), .z(z)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_mode = 0;
  bit m_last = 1'b0, m_nrzi = 1'b0, m_dpol = 1'b0, m_par = 1'b0;
  int m_zrun = 0;
  int q[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] lvl(bit p);
    return p ? 2'b01 : 2'b11;
  endfunction

  function automatic string req_of(bit v, bit chg, int md);
    if (!v) return "R12";
    if (chg) return "R13";
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      8: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic slot(bit v, bit b, int md);
    logic [1:0] f, s;
    bit chg, fp, mark;
    int d, t;
    int pat8[8] = '{0, 0, 0, 2, 1, 0, 2, 1};
    string r;
    chg = (md != m_mode);
    if (chg) begin
      m_mode = md; m_last = 0; m_nrzi = 0; m_dpol = 0; m_par = 0; m_zrun = 0;
      q.delete();
      d = (md == 8) ? 4 : 8;
      repeat (d) q.push_back(0);
    end
    f = 2'b00; s = 2'b00;
    if (v) begin
      case (md)
        0: f = b ? 2'b01 : 2'b00;
        1: begin if (b) m_nrzi = !m_nrzi; f = m_nrzi ? 2'b01 : 2'b00; s = f; end
        2: begin f = b ? 2'b11 : 2'b01; s = f; end
        3: begin f = b ? 2'b01 : 2'b11; s = b ? 2'b11 : 2'b01; end
        4: begin
          fp = b ? m_dpol : !m_dpol;
          f = lvl(fp); s = lvl(!fp); m_dpol = !fp;
        end
        5, 6: begin
          mark = (md == 5) ? b : !b;
          if (mark) begin m_last = !m_last; f = lvl(m_last); end
          s = f;
        end
        7, 8: begin
          d = (md == 7) ? 8 : 4;
          q.push_back(b ? 1 : 0);
          if (b) begin
            m_zrun = 0; m_par = !m_par;
          end else begin
            m_zrun++;
            if (m_zrun == d) begin
              m_zrun = 0;
              if (md == 7) begin
                for (int k = 0; k < 8; k++) q[k+1] = pat8[k];
              end else begin
                q[1] = m_par ? 0 : 1; q[2] = 0; q[3] = 0; q[4] = 2;
                m_par = 0;
              end
            end
          end
          t = q.pop_front();
          if (t == 1) begin m_last = !m_last; f = lvl(m_last); end
          else if (t == 2) f = lvl(m_last);
          s = f;
        end
        default: begin f = 2'b00; s = 2'b00; end
      endcase
    end
    r = req_of(v, chg, md);
    bit_valid = v; bit_in = b; mode = md[3:0];
    @(negedge clk);
    check(r, z, f);
    check("R14", {1'b0, half_ph}, 2'b00);
    @(negedge clk);
    check(r, z, s);
    check("R14", {1'b0, half_ph}, 2'b01);
  endtask

  task automatic run_bits(int md, logic [31:0] bits, int n);
    for (int i = 0; i < n; i++) slot(1'b1, bits[n-1-i], md);
  endtask

  task automatic run_rand(int md, int n, bit sparse);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (sparse) slot(1'b1, lfsr[2:0] == 3'b111, md);
      else slot(lfsr[5:0] != 6'd0, lfsr[0], md);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", z, 2'b00);
    check("R1", {1'b0, half_ph}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", z, 2'b00);
    check("R1", {1'b0, half_ph}, 2'b01);

    run_bits(0, 32'b10110, 5);
    run_rand(0, 30, 1'b0);
    run_bits(1, 32'b1101001, 7);
    run_rand(1, 30, 1'b0);
    run_bits(2, 32'b1001, 4);
    run_bits(3, 32'b10110, 5);
    run_bits(4, 32'b001101, 6);
    run_rand(4, 30, 1'b0);
    run_bits(5, 32'b101101, 6);
    slot(1'b0, 1'b1, 5);
    run_bits(5, 32'b11, 2);
    run_bits(6, 32'b01001, 5);
    run_rand(6, 30, 1'b0);
    // R9: substitution after a positive mark, then after a negative one
    run_bits(7, 32'b1000000001, 10);
    run_bits(7, 32'b110000000000000000, 18);
    run_bits(7, 32'd0, 16);
    run_bits(7, 32'b1, 1);
    run_bits(7, 32'd0, 12);
    run_rand(7, 200, 1'b1);
    slot(1'b0, 1'b0, 7);
    run_rand(7, 40, 1'b1);
    // R10: even and odd mark counts ahead of a four-zero run
    run_bits(8, 32'b0000110000100001, 16);
    run_bits(8, 32'd0, 12);
    run_rand(8, 200, 1'b1);
    slot(1'b0, 1'b1, 8);
    run_rand(8, 40, 1'b1);
    run_bits(9, 32'b1101, 4);
    run_bits(15, 32'b0110, 4);
    // R13: polarity restarts after a mode change
    run_bits(5, 32'b111, 3);
    run_bits(6, 32'b1, 1);
    run_bits(5, 32'b11, 2);
    run_bits(7, 32'b1, 1);
    run_bits(8, 32'd0, 8);
    slot(1'b1, 1'b1, 9);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule